// File: doc/BRIEF.md
# Dual-Bank OUT Pipe Transmit Buffer Controller

This block manages the transmit buffer of a host-side USB OUT pipe. The buffer holds one or two banks of bytes. Software fills the bank it currently owns through a byte write port. It then hands the bank to the link side by writing the release strobe. With two banks, the software pointer moves to the other bank on each release. Software can therefore fill one bank while the link side sends the other, and packets follow each other with no gap.

The link side sees a send request and a packet length. It can read the bank it is serving at any byte address. It answers each send with an acknowledge pulse once the device has accepted the packet. An acknowledge gives the bank back to software as empty and raises that bank's transmit-done flag. Software clears the flag by writing one to a clear strobe. The flag must be cleared before the bank can be released again, and a release attempted while the flag is set is ignored. If software drops start-of-frame generation to enter suspend while a bank waits to be sent, the frame-active output stays high until nothing is pending.

Top module: `out_pipe_bank_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every bank is owned by software and is empty, and both pointers select bank 0. The outputs then read `sw_fifocon`=1, `sw_txout`=0, `sw_byte_cnt`=0, `sw_bank`=0, `link_send_req`=0 and `link_bank`=0.
- R2: An accepted `sw_wr_en` stores `sw_wr_data` at byte address equal to the bank's count, then adds one to that count. `link_len` shows the count of the bank at `link_bank`. `link_rd_data` returns the byte stored at `link_rd_addr` of that bank.
- R3: A byte write is ignored, and changes neither the count nor the stored data, when the current software bank is full, is owned by hardware, or is released in the same cycle.
- R4: A release (`sw_fifocon_clr` high while `sw_fifocon`=1 and `sw_txout`=0) hands the bank to hardware. With two banks, `sw_bank` toggles, and every software status output then describes the new bank.
- R5: A release attempted while `sw_txout`=1 is ignored. Ownership and `sw_bank` stay unchanged.
- R6: `sw_txout_clr` clears the transmit-done flag of the current software bank only. It changes no count, data, ownership or pointer. If an acknowledge sets that same flag in the same cycle, the flag ends set.
- R7: `link_ack` while `link_send_req`=1 returns the served bank to software with a zero count and its flag set, and advances `link_bank`. `link_ack` while `link_send_req`=0 is ignored.
- R8: `sw_rwall` is 1 exactly when the current software bank is owned by software and holds fewer than BANK_BYTES bytes.
- R9: The link side serves banks in the order in which they were released. `link_send_req` is 1 exactly when the bank at `link_bank` is owned by hardware.
- R10: `host_frame_active` is 1 when `sw_sof_en`=1 or any bank is owned by hardware, so a suspend request is overridden while data is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_wr_en | input | 1 | Software byte write strobe |
| sw_wr_data | input | 8 | Byte to write |
| sw_txout_clr | input | 1 | Write-one clear of the transmit-done flag |
| sw_fifocon_clr | input | 1 | Release the current software bank to hardware |
| sw_sof_en | input | 1 | Start-of-frame enable; low requests suspend |
| sw_txout | output | 1 | Transmit-done flag of the current software bank |
| sw_fifocon | output | 1 | Current software bank is owned by software |
| sw_rwall | output | 1 | Current software bank accepts more bytes |
| sw_bank | output | 1 | Index of the current software bank |
| sw_byte_cnt | output | $clog2(BANK_BYTES+1) | Byte count of the current software bank |
| link_send_req | output | 1 | A released bank is waiting to be sent |
| link_bank | output | 1 | Index of the bank the link side serves |
| link_len | output | $clog2(BANK_BYTES+1) | Packet length of the served bank |
| link_rd_addr | input | $clog2(BANK_BYTES) | Byte address read by the link side |
| link_rd_data | output | 8 | Byte at that address in the served bank |
| link_ack | input | 1 | Device acknowledged the served bank |
| host_frame_active | output | 1 | Frame generation active, including the suspend override |

## Verification
The assertions check on every cycle the rules that hold locally:
- the count never exceeds the bank size;
- a write never lands in a hardware-owned bank;
- a release always raises a send request and, with two banks, toggles the software pointer;
- a release blocked by a set flag leaves the pointer in place;
- an acknowledge returns an empty bank with its flag set;
- room-available implies software ownership;
- a pending bank keeps frames active.

Some behaviour can only be shown by the bench's reference model and its scenarios:
- the order in which banks are served;
- the stored bytes read back by the link side;
- full-bank and wrong-owner writes being dropped;
- a flag set by an acknowledge winning over a clear in the same cycle;
- long random mixes of all strobes.

// File: rtl/opb_pkg.sv
// Package: shared helpers for the OUT pipe bank controller.
// Assumes a bank count of 1 or 2; bank indices are one bit wide.
package opb_pkg;

    typedef logic [7:0] byte_t;

    // Next bank in round-robin order; stays on bank 0 with a single bank.
    function automatic logic next_bank(input logic cur, input int unsigned nbanks);
        return (nbanks == 2) ? ~cur : 1'b0;
    endfunction

endpackage

// File: rtl/opb_bank_state.sv
// Module: per-bank state of the OUT pipe buffer.
// Holds the hardware-ownership bit, the transmit-done flag and the byte count.
// Assumes the caller never asserts a write or release hit on a hardware-owned
// bank and never asserts an acknowledge hit on a software-owned bank.
module opb_bank_state #(
    parameter int BANK_BYTES = 64,
    localparam int CW = $clog2(BANK_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hit,
    input  logic          rel_hit,
    input  logic          ack_hit,
    input  logic          clr_hit,
    output logic          hw_owned,
    output logic          done_flag,
    output logic [CW-1:0] count
);

    // State update: clear first, so an acknowledge in the same cycle wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hw_owned  <= 1'b0;
            done_flag <= 1'b0;
            count     <= '0;
        end else begin
            if (clr_hit) done_flag <= 1'b0;
            if (ack_hit) begin
                done_flag <= 1'b1;
                hw_owned  <= 1'b0;
                count     <= '0;
            end
            if (wr_hit)  count    <= count + 1'b1;
            if (rel_hit) hw_owned <= 1'b1;
        end
    end

    AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(BANK_BYTES)); // R3
    AST_NO_WR_HW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |-> !hw_owned); // R3
    AST_ACK_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        ack_hit |=> (!hw_owned && done_flag && count == '0)); // R7
    AST_REL_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        rel_hit |=> hw_owned); // R4

endmodule

// File: rtl/opb_bank_mem.sv
// Module: byte storage for all banks of the OUT pipe.
// One synchronous write port for software and one combinational read port
// for the link side. Contents are not reset; counts define valid bytes.
module opb_bank_mem #(
    parameter int NBANKS     = 2,
    parameter int BANK_BYTES = 64,
    localparam int AW    = $clog2(BANK_BYTES),
    localparam int DEPTH = NBANKS * BANK_BYTES,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           we,
    input  logic           wbank,
    input  logic [AW-1:0]  waddr,
    input  opb_pkg::byte_t wdata,
    input  logic           rbank,
    input  logic [AW-1:0]  raddr,
    output opb_pkg::byte_t rdata
);

    opb_pkg::byte_t store [DEPTH];
    logic [IW-1:0]  widx, ridx;

    // Flat index: bank offset plus byte address.
    always_comb begin
        widx = (wbank ? IW'(BANK_BYTES) : '0) + IW'(waddr);
        ridx = (rbank ? IW'(BANK_BYTES) : '0) + IW'(raddr);
    end

    // Byte write from the software side.
    always_ff @(posedge clk) begin
        if (we) store[widx] <= wdata;
    end

    assign rdata = store[ridx];

endmodule

// File: rtl/out_pipe_bank_ctrl.sv
// Module: top of the OUT pipe transmit buffer controller.
// Decodes the software strobes and the link acknowledge into per-bank hits.
// Keeps the software and link bank pointers and drives the status outputs,
// including the suspend override.
// Assumes NBANKS is 1 or 2 and that link_ack is a one-cycle pulse per packet.
module out_pipe_bank_ctrl #(
    parameter int NBANKS     = 2,
    parameter int BANK_BYTES = 64,
    localparam int CW = $clog2(BANK_BYTES + 1),
    localparam int AW = $clog2(BANK_BYTES)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sw_wr_en,
    input  logic [7:0]     sw_wr_data,
    input  logic           sw_txout_clr,
    input  logic           sw_fifocon_clr,
    input  logic           sw_sof_en,
    output logic           sw_txout,
    output logic           sw_fifocon,
    output logic           sw_rwall,
    output logic           sw_bank,
    output logic [CW-1:0]  sw_byte_cnt,
    output logic           link_send_req,
    output logic           link_bank,
    output logic [CW-1:0]  link_len,
    input  logic [AW-1:0]  link_rd_addr,
    output logic [7:0]     link_rd_data,
    input  logic           link_ack,
    output logic           host_frame_active
);

    logic          sw_ptr, lk_ptr;
    logic [1:0]    hw_v, done_v;
    logic [CW-1:0] cnt_v [2];
    logic          sw_own, rel_ok, wr_ok, ack_ok;

    // Strobe qualification against the current ownership state.
    always_comb begin
        sw_own = !hw_v[sw_ptr];
        rel_ok = sw_fifocon_clr && sw_own && !done_v[sw_ptr];
        wr_ok  = sw_wr_en && sw_own && (cnt_v[sw_ptr] < CW'(BANK_BYTES)) && !rel_ok;
        ack_ok = link_ack && hw_v[lk_ptr];
    end

    for (genvar b = 0; b < 2; b++) begin : g_bank
        if (b < NBANKS) begin : g_real
            opb_bank_state #(.BANK_BYTES(BANK_BYTES)) u_state (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_hit   (wr_ok  && (sw_ptr == 1'(b))),
                .rel_hit  (rel_ok && (sw_ptr == 1'(b))),
                .ack_hit  (ack_ok && (lk_ptr == 1'(b))),
                .clr_hit  (sw_txout_clr && (sw_ptr == 1'(b))),
                .hw_owned (hw_v[b]),
                .done_flag(done_v[b]),
                .count    (cnt_v[b])
            );
        end else begin : g_tie
            assign hw_v[b]   = 1'b0;
            assign done_v[b] = 1'b0;
            assign cnt_v[b]  = '0;
        end
    end

    // Pointer advance: software on release, link on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_ptr <= 1'b0;
            lk_ptr <= 1'b0;
        end else begin
            if (rel_ok) sw_ptr <= opb_pkg::next_bank(sw_ptr, NBANKS);
            if (ack_ok) lk_ptr <= opb_pkg::next_bank(lk_ptr, NBANKS);
        end
    end

    opb_bank_mem #(.NBANKS(NBANKS), .BANK_BYTES(BANK_BYTES)) u_mem (
        .clk  (clk),
        .we   (wr_ok),
        .wbank(sw_ptr),
        .waddr(AW'(cnt_v[sw_ptr])),
        .wdata(sw_wr_data),
        .rbank(lk_ptr),
        .raddr(link_rd_addr),
        .rdata(link_rd_data)
    );

    // Status outputs for both sides.
    always_comb begin
        sw_fifocon        = sw_own;
        sw_txout          = done_v[sw_ptr];
        sw_byte_cnt       = cnt_v[sw_ptr];
        sw_rwall          = sw_own && (cnt_v[sw_ptr] < CW'(BANK_BYTES));
        sw_bank           = sw_ptr;
        link_send_req     = hw_v[lk_ptr];
        link_bank         = lk_ptr;
        link_len          = cnt_v[lk_ptr];
        host_frame_active = sw_sof_en || (|hw_v);
    end

    AST_REL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_fifocon_clr && sw_fifocon && !sw_txout) |=> link_send_req); // R4
    AST_DUAL_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        (NBANKS == 2 && sw_fifocon_clr && sw_fifocon && !sw_txout) |=> (sw_bank != $past(sw_bank))); // R4
    AST_ORDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_fifocon_clr && sw_txout) |=> $stable(sw_bank)); // R5
    AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (link_ack && !link_send_req) |=> $stable(link_bank)); // R7
    AST_RWALL_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rwall |-> sw_fifocon); // R8
    AST_SUSP_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        link_send_req |-> host_frame_active); // R10

endmodule

// File: tb/sim_out_pipe_bank_ctrl.sv
// Bench: a behavioural reference model is compared with the design each cycle,
// with directed scenarios followed by a random phase.
module sim_out_pipe_bank_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int BB = 8;
    localparam int CW = $clog2(BB + 1);
    localparam int AW = $clog2(BB);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, tx_clr = 1'b0, fc_clr = 1'b0, sof_en = 1'b1, ack = 1'b0;
    logic [7:0]    wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic          o_txout, o_fifocon, o_rwall, o_bank, o_req, o_lbank, o_hfa;
    logic [CW-1:0] o_cnt, o_len;
    logic [7:0]    o_rdata;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // Reference model state.
    int own  [2];
    int flag [2];
    int cnt  [2];
    int mm   [2][BB];
    int sp, lp;

    always #(CLK_PERIOD / 2) clk = ~clk;

    out_pipe_bank_ctrl #(.NBANKS(2), .BANK_BYTES(BB)) u0 (
        .clk(clk), .rst_n(rst_n),
        .sw_wr_en(wr_en), .sw_wr_data(wr_data),
        .sw_txout_clr(tx_clr), .sw_fifocon_clr(fc_clr), .sw_sof_en(sof_en),
        .sw_txout(o_txout), .sw_fifocon(o_fifocon), .sw_rwall(o_rwall),
        .sw_bank(o_bank), .sw_byte_cnt(o_cnt),
        .link_send_req(o_req), .link_bank(o_lbank), .link_len(o_len),
        .link_rd_addr(rd_addr), .link_rd_data(o_rdata), .link_ack(ack),
        .host_frame_active(o_hfa)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Model step on a clock edge, using the inputs held over that edge.
    task automatic model_step();
        int osp, olp;
        bit rel, wr, ak;
        osp = sp;
        olp = lp;
        if (!rst_n) begin
            for (int b = 0; b < 2; b++) begin
                own[b] = 0;
                flag[b] = 0;
                cnt[b] = 0;
            end
            sp = 0;
            lp = 0;
            return;
        end
        rel = fc_clr && own[osp] == 0 && flag[osp] == 0;
        wr  = wr_en && own[osp] == 0 && cnt[osp] < BB && !rel;
        ak  = ack && own[olp] == 1;
        if (tx_clr) flag[osp] = 0;
        if (ak) begin
            own[olp] = 0;
            flag[olp] = 1;
            cnt[olp] = 0;
            lp = 1 - olp;
        end
        if (wr) begin
            mm[osp][cnt[osp]] = int'(wr_data);
            cnt[osp]++;
        end
        if (rel) begin
            own[osp] = 1;
            sp = 1 - osp;
        end
    endtask

    // Compare all outputs with the model.
    task automatic compare_all();
        chk(int'(o_fifocon), (own[sp] == 0) ? 1 : 0, "R4 sw_fifocon");
        chk(int'(o_txout), flag[sp], "R6 sw_txout");
        chk(int'(o_cnt), cnt[sp], "R2 sw_byte_cnt");
        chk(int'(o_rwall), (own[sp] == 0 && cnt[sp] < BB) ? 1 : 0, "R8 sw_rwall");
        chk(int'(o_bank), sp, "R4 sw_bank");
        chk(int'(o_req), own[lp], "R9 link_send_req");
        chk(int'(o_lbank), lp, "R9 link_bank");
        chk(int'(o_len), cnt[lp], "R2 link_len");
        chk(int'(o_hfa), (sof_en || own[0] == 1 || own[1] == 1) ? 1 : 0, "R10 host_frame_active");
        if (own[lp] == 1 && int'(rd_addr) < cnt[lp])
            chk(int'(o_rdata), mm[lp][rd_addr], "R2 link_rd_data");
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        #(CLK_PERIOD / 2);
        compare_all();
    endtask

    task automatic do_write(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic pulse_rel();
        fc_clr = 1'b1;
        tick();
        fc_clr = 1'b0;
    endtask

    task automatic pulse_clr();
        tx_clr = 1'b1;
        tick();
        tx_clr = 1'b0;
    endtask

    task automatic pulse_ack();
        ack = 1'b1;
        tick();
        ack = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk(int'(o_fifocon), 1, "R1 fifocon after reset");
        chk(int'(o_txout), 0, "R1 txout after reset");
        chk(int'(o_cnt), 0, "R1 count after reset");
        chk(int'(o_bank), 0, "R1 sw_bank after reset");
        chk(int'(o_req), 0, "R1 send_req after reset");
        chk(int'(o_lbank), 0, "R1 link_bank after reset");

        // R2 writes into bank 0
        do_write(8'hA1);
        do_write(8'hA2);
        do_write(8'hA3);
        chk(int'(o_cnt), 3, "R2 count after three writes");

        // R4 release of bank 0
        pulse_rel();
        chk(int'(o_bank), 1, "R4 pointer toggled");
        chk(int'(o_fifocon), 1, "R4 new bank status");
        chk(int'(o_req), 1, "R4 send request raised");
        chk(int'(o_len), 3, "R2 link_len");
        rd_addr = 3'd1;
        #1;
        chk(int'(o_rdata), 8'hA2, "R2 stored byte");

        // R3 and R8: fill bank 1, then overflow
        for (int i = 0; i < BB; i++) do_write(8'hB0 + 8'(i));
        chk(int'(o_cnt), BB, "R8 full count");
        chk(int'(o_rwall), 0, "R8 rwall low when full");
        do_write(8'hFF);
        chk(int'(o_cnt), BB, "R3 write to full bank ignored");

        // R3: write to a hardware-owned bank
        pulse_rel();
        chk(int'(o_fifocon), 0, "R4 bank0 still hardware owned");
        do_write(8'h55);
        chk(int'(o_cnt), 3, "R3 write to hw bank ignored");
        chk(int'(o_rdata), 8'hA2, "R3 data unchanged");

        // R10: suspend request overridden while data is pending
        sof_en = 1'b0;
        tick();
        chk(int'(o_hfa), 1, "R10 suspend overridden");

        // R7: acknowledge of bank 0
        pulse_ack();
        chk(int'(o_fifocon), 1, "R7 bank returned");
        chk(int'(o_txout), 1, "R7 flag set");
        chk(int'(o_cnt), 0, "R7 count emptied");
        chk(int'(o_lbank), 1, "R9 link moved to bank1");
        chk(int'(o_len), BB, "R9 bank1 length");

        // R5: release while the flag is set is ignored
        pulse_rel();
        chk(int'(o_bank), 0, "R5 pointer held");
        chk(int'(o_fifocon), 1, "R5 ownership held");

        // R6: clear the flag, nothing else moves
        pulse_clr();
        chk(int'(o_txout), 0, "R6 flag cleared");
        chk(int'(o_bank), 0, "R6 pointer unchanged");
        chk(int'(o_req), 1, "R6 link side unchanged");

        // R9/R10: drain bank 1, suspend takes effect
        pulse_ack();
        chk(int'(o_req), 0, "R9 no request when idle");
        chk(int'(o_hfa), 0, "R10 suspend when idle");
        pulse_ack();
        chk(int'(o_lbank), 0, "R7 idle ack ignored");

        // R6: acknowledge sets the flag over a same-cycle clear
        do_write(8'h11);
        pulse_rel();
        pulse_clr();
        pulse_rel();
        chk(int'(o_fifocon), 0, "R4 both banks hardware owned");
        tx_clr = 1'b1;
        ack = 1'b1;
        tick();
        tx_clr = 1'b0;
        ack = 1'b0;
        chk(int'(o_txout), 1, "R6 set wins over clear");
        chk(int'(o_lbank), 1, "R9 link follows release order");
        pulse_ack();
        sof_en = 1'b1;

        // Random phase compared against the model every cycle
        for (int n = 0; n < 2000; n++) begin
            wr_en   = ($urandom_range(0, 99) < 40);
            wr_data = 8'($urandom);
            tx_clr  = ($urandom_range(0, 99) < 15);
            fc_clr  = ($urandom_range(0, 99) < 15);
            ack     = ($urandom_range(0, 99) < 20);
            sof_en  = ($urandom_range(0, 99) < 70);
            rd_addr = AW'($urandom);
            tick();
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule